// File: doc/BRIEF.md
# Segmented Successive-Approximation Bit-Decision Controller

This block sequences one successive-approximation conversion for a 7-bit coarse converter stage whose capacitor array is split into a unary upper segment and a binary lower segment. A single-cycle start pulse opens a two-cycle input sampling window. After that window, a one-hot pointer walks from the most significant bit to the least significant bit, one bit per clock. In each cycle the bit under test is raised on the array controls. The one-bit comparator answer is then latched into that bit at the next clock edge.

The three upper bits of the trial word reach the array as a 7-line thermometer bus, and the four lower bits reach it as plain binary lines. When the last decision is stored, the block gives a one-cycle completion pulse and raises a residue-ready level. That level tells the following amplifier that the array now holds the final code and its residue can be taken. The code and the array controls then stay put until the next start.

Top module: `sar_seg_ctrl`

## Requirements
- R1: After reset, samp_o, done_o and resid_rdy_o are 0, code_o is 0, and every line of dac_therm_o and dac_bin_o is 0.
- R2: When start_i is sampled high at a clock edge, samp_o is 1 in exactly the two clock cycles that follow that edge. In those cycles the array controls are all 0 and no bit is under test.
- R3: After the sampling window, bits are tried MSB first, one per cycle. In the trial cycle for bit i, the array word (thermometer count times 16 plus the binary lines) has the already-decided upper bits, bit i set to 1, and all lower bits 0.
- R4: cmp_i is sampled at the edge that ends a trial cycle. A value of 1 keeps the bit under test and 0 clears it. With a comparator that answers (trial word <= input level), the final code_o equals the input level for every level 0 to 127. code_o[6] is the most significant bit.
- R5: Thermometer line j (j = 0..6) is 1 exactly when the value of trial bits [6:4] is greater than j. So code 000 drives all 0 and code 111 drives all 7 lines. Binary line k (k = 0..3) carries trial bit k.
- R6: done_o is a one-cycle pulse in the cycle after the edge that stores the LSB, which is the 9th edge after the start edge. resid_rdy_o rises in that same cycle, which is the 8th step after sampling ends.
- R7: Once resid_rdy_o is 1, code_o, the array controls and resid_rdy_o hold until the next start, whatever cmp_i does. cmp_i is also ignored during sampling.
- R8: A start during a conversion abandons it. All decided bits clear at that edge, sampling begins again, and the new conversion completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start pulse |
| cmp_i | input | 1 | Comparator decision, 1 keeps the bit under test |
| samp_o | output | 1 | Input sampling window |
| dac_therm_o | output | 7 | Unary controls for the upper segment |
| dac_bin_o | output | 4 | Binary controls for the lower segment |
| code_o | output | 7 | Decided code, final once resid_rdy_o is 1 |
| done_o | output | 1 | One-cycle completion pulse |
| resid_rdy_o | output | 1 | Residue ready for amplification, held until the next start |

## Verification
The assertions take start_i to be a pulse that, when it lands during a conversion, restarts it cleanly. They also take cmp_i to be meaningful only in trial cycles, so no property constrains its value. The bench drives start_i for a single cycle at a falling edge. It answers cmp_i from a comparator model that reads only the array control ports. It also drives cmp_i deliberately during sampling and after completion, to show that the block ignores it there. Every input level from 0 to 127 is converted, and one conversion is cut short by a fresh start partway through its trials.

// File: rtl/sar_seg_pkg.sv
package sar_seg_pkg;

    localparam int unsigned DEF_RES_BITS = 7;
    localparam int unsigned DEF_SEG_BITS = 3;
    localparam int unsigned DEF_SAMP_CYC = 2;

    // number of unary lines for a segment of seg bits
    function automatic int unsigned unary_lines(input int unsigned seg);
        return (32'd1 << seg) - 32'd1;
    endfunction

endpackage

// File: rtl/sar_samp_seq.sv
module sar_samp_seq #(
    parameter int unsigned SAMP_CYC = sar_seg_pkg::DEF_SAMP_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic samp_o,
    output logic launch_o
);
    localparam logic [SAMP_CYC-1:0] FIRST = {{(SAMP_CYC-1){1'b0}}, 1'b1};

    logic [SAMP_CYC-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst)          win_q <= '0;
        else if (start_i) win_q <= FIRST;
        else              win_q <= win_q << 1;
    end

    assign samp_o   = |win_q;
    // last sampling cycle hands over to the pointer chain
    assign launch_o = win_q[SAMP_CYC-1] & ~start_i;
endmodule

// File: rtl/sar_ptr_chain.sv
module sar_ptr_chain #(
    parameter int unsigned NBITS = sar_seg_pkg::DEF_RES_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             launch_i,
    output logic [NBITS-1:0] ptr_o,
    output logic             done_o
);
    localparam logic [NBITS-1:0] TOP = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] ptr_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst)           ptr_q <= '0;
        else if (start_i)  ptr_q <= '0;
        else if (launch_i) ptr_q <= TOP;
        else               ptr_q <= ptr_q >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= ptr_q[0] & ~start_i;
    end

    assign ptr_o  = ptr_q;
    assign done_o = done_q;
endmodule

// File: rtl/sar_decision_chain.sv
module sar_decision_chain #(
    parameter int unsigned NBITS = sar_seg_pkg::DEF_RES_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic [NBITS-1:0] ptr_i,
    output logic [NBITS-1:0] res_o
);
    logic [NBITS-1:0] res_q;

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           res_q[b] <= 1'b0;
            else if (start_i)  res_q[b] <= 1'b0;
            else if (ptr_i[b]) res_q[b] <= cmp_i;
        end
    end

    assign res_o = res_q;
endmodule

// File: rtl/seg_therm_dec.sv
module seg_therm_dec #(
    parameter int unsigned SEG_BITS = sar_seg_pkg::DEF_SEG_BITS,
    parameter int unsigned LINES    = sar_seg_pkg::unary_lines(SEG_BITS)
) (
    input  logic [SEG_BITS-1:0] val_i,
    output logic [LINES-1:0]    therm_o
);
    for (genvar j = 0; j < LINES; j++) begin : g_line
        assign therm_o[j] = (val_i > SEG_BITS'(j));
    end
endmodule

// File: rtl/sar_seg_ctrl.sv
module sar_seg_ctrl #(
    parameter int unsigned NBITS    = sar_seg_pkg::DEF_RES_BITS,
    parameter int unsigned SEG_BITS = sar_seg_pkg::DEF_SEG_BITS,
    parameter int unsigned SAMP_CYC = sar_seg_pkg::DEF_SAMP_CYC,
    localparam int unsigned THW     = sar_seg_pkg::unary_lines(SEG_BITS),
    localparam int unsigned BIN_W   = NBITS - SEG_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             samp_o,
    output logic [THW-1:0]   dac_therm_o,
    output logic [BIN_W-1:0] dac_bin_o,
    output logic [NBITS-1:0] code_o,
    output logic             done_o,
    output logic             resid_rdy_o
);
    logic             launch_w;
    logic [NBITS-1:0] ptr_w;
    logic [NBITS-1:0] res_w;
    logic [NBITS-1:0] trial_w;
    logic             resid_q;

    sar_samp_seq #(.SAMP_CYC(SAMP_CYC)) u_samp (
        .clk(clk), .rst(rst), .start_i(start_i),
        .samp_o(samp_o), .launch_o(launch_w)
    );

    sar_ptr_chain #(.NBITS(NBITS)) u_ptr (
        .clk(clk), .rst(rst), .start_i(start_i), .launch_i(launch_w),
        .ptr_o(ptr_w), .done_o(done_o)
    );

    sar_decision_chain #(.NBITS(NBITS)) u_dec (
        .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
        .ptr_i(ptr_w), .res_o(res_w)
    );

    // bit under test raised on top of decided bits
    assign trial_w = res_w | ptr_w;

    seg_therm_dec #(.SEG_BITS(SEG_BITS), .LINES(THW)) u_therm (
        .val_i(trial_w[NBITS-1 -: SEG_BITS]),
        .therm_o(dac_therm_o)
    );

    assign dac_bin_o = trial_w[BIN_W-1:0];
    assign code_o    = res_w;

    always_ff @(posedge clk) begin
        if (rst)           resid_q <= 1'b0;
        else if (start_i)  resid_q <= 1'b0;
        else if (ptr_w[0]) resid_q <= 1'b1;
    end

    assign resid_rdy_o = resid_q;
endmodule

// File: rtl/sar_seg_ctrl_chk.sv
module sar_seg_ctrl_chk #(
    parameter int unsigned NBITS    = 7,
    parameter int unsigned SEG_BITS = 3,
    localparam int unsigned THW     = (1 << SEG_BITS) - 1,
    localparam int unsigned BIN_W   = NBITS - SEG_BITS
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             samp_o,
    input logic             done_o,
    input logic             resid_rdy_o,
    input logic [NBITS-1:0] code_o,
    input logic [THW-1:0]   dac_therm_o,
    input logic [BIN_W-1:0] dac_bin_o,
    input logic [NBITS-1:0] ptr
);
    AST_SAMP_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_i |=> samp_o); // R2
    AST_NO_TRIAL_IN_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        samp_o |-> (ptr == '0)); // R2
    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ptr)); // R3
    AST_TEST_BIT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (dac_bin_o & ptr[BIN_W-1:0]) == ptr[BIN_W-1:0]); // R3
    AST_THERM_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (dac_therm_o & (dac_therm_o + THW'(1))) == '0); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6
    AST_DONE_WITH_RESID: assert property (@(posedge clk) disable iff (rst)
        done_o |-> resid_rdy_o); // R6
    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (resid_rdy_o && !start_i) |=> ($stable(code_o) && resid_rdy_o)); // R7
endmodule

bind sar_seg_ctrl sar_seg_ctrl_chk #(.NBITS(NBITS), .SEG_BITS(SEG_BITS)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .samp_o(samp_o),
    .done_o(done_o), .resid_rdy_o(resid_rdy_o), .code_o(code_o),
    .dac_therm_o(dac_therm_o), .dac_bin_o(dac_bin_o), .ptr(ptr_w)
);

// File: tb/sar_seg_ctrl_bench.sv
module sar_seg_ctrl_bench;
    localparam int NB = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       cmp_i = 1'b0;
    logic       samp_o, done_o, resid_rdy_o;
    logic [6:0] dac_therm_o;
    logic [3:0] dac_bin_o;
    logic [6:0] code_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sar_seg_ctrl u_sar_seg_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
        .samp_o(samp_o), .dac_therm_o(dac_therm_o), .dac_bin_o(dac_bin_o),
        .code_o(code_o), .done_o(done_o), .resid_rdy_o(resid_rdy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // word seen by the array: unary count weighs 16, binary lines weigh 1
    function automatic int dac_word();
        return $countones(dac_therm_o) * 16 + int'(dac_bin_o);
    endfunction

    task automatic run_conv(input int vin);
        int w;
        int ex;
        @(negedge clk); start_i = 1'b1; cmp_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(samp_o == 1'b1, "R2 sample cycle 1", int'(samp_o), 1);
        chk(code_o == 7'd0, "R8 bits cleared on start", int'(code_o), 0);
        chk(dac_word() == 0, "R2 array idle while sampling", dac_word(), 0);
        @(negedge clk);
        chk(samp_o == 1'b1, "R2 sample cycle 2", int'(samp_o), 1);
        for (int i = NB - 1; i >= 0; i--) begin
            @(negedge clk);
            if (i == NB - 1) chk(samp_o == 1'b0, "R2 window length", int'(samp_o), 0);
            w  = dac_word();
            ex = ((vin >> (i + 1)) << (i + 1)) | (1 << i);
            chk(w == ex, "R3 trial word", w, ex);
            chk(done_o == 1'b0, "R6 no early done", int'(done_o), 0);
            cmp_i = (w <= vin);  // R4 comparator model
        end
        @(negedge clk);
        cmp_i = ~cmp_i;
        chk(done_o == 1'b1, "R6 done after LSB", int'(done_o), 1);
        chk(resid_rdy_o == 1'b1, "R6 residue ready", int'(resid_rdy_o), 1);
        chk(int'(code_o) == vin, "R4 final code", int'(code_o), vin);
        chk(int'(dac_therm_o) == (1 << (vin >> 4)) - 1, "R5 thermometer lines",
            int'(dac_therm_o), (1 << (vin >> 4)) - 1);
        chk(int'(dac_bin_o) == (vin & 15), "R5 binary lines", int'(dac_bin_o), vin & 15);
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done one cycle", int'(done_o), 0);
        chk(int'(code_o) == vin, "R7 code held", int'(code_o), vin);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(samp_o == 1'b0, "R1 samp", int'(samp_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        chk(resid_rdy_o == 1'b0, "R1 resid", int'(resid_rdy_o), 0);
        chk(code_o == 7'd0, "R1 code", int'(code_o), 0);
        chk(dac_word() == 0, "R1 array", dac_word(), 0);

        for (int v = 0; v < 128; v++) run_conv(v);

        // R7 hold with comparator toggling after completion
        run_conv(93);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cmp_i = k[0];
            chk(int'(code_o) == 93, "R7 code hold", int'(code_o), 93);
            chk(dac_word() == 93, "R7 array hold", dac_word(), 93);
            chk(resid_rdy_o == 1'b1, "R7 resid hold", int'(resid_rdy_o), 1);
        end

        // R8 abort after three trials with all keeps, then restart
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; cmp_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(resid_rdy_o == 1'b0, "R8 resid low mid conversion", int'(resid_rdy_o), 0);
        run_conv(37);
        chk(int'(code_o) == 37, "R8 restarted result", int'(code_o), 37);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule